// File: doc/BRIEF.md
# Configuration Status Interrupt Monitor

This block watches twelve status lines coming from a programmable fabric while it is being loaded and turns them into a single interrupt request. Each line passes through a synchronizer first. Per-line control registers then decide whether the line takes part (arm), whether it is hidden from the interrupt (hide), whether it is detected by level or by edge (trigger kind), and which level or edge counts as active (polarity).

Software reads a pending view with hidden lines removed, a pending view without that filtering, and the live synchronized value of all twelve lines. It acknowledges pending bits by writing ones to an acknowledge register. All registers share one bit layout: 0 chip-ok, 1 load-done, 2 wake-done, 3 check-error, 4 link-load-done, 5 partial-ready, 6 partial-error, 7 partial-done, 8 reconfigure pin, 9 chip-ok pin, 10 load-done pin, 11 power-good.

The register port is a single-cycle write strobe with a byte address, plus a combinational read of the addressed register.

Top module: `cfg_status_irq`

## Requirements
- R1: After reset, every readable register returns zero and `irq_o` is low.
- R2: The live register (byte address 0x850) returns the synchronized status lines in bits [11:0], two clock edges after a line changes, and zero in bits [31:12].
- R3: The arm (0x830), hide (0x834), trigger-kind (0x838) and polarity (0x83C) registers store `wdata_i[11:0]` on a write and read it back with bits [31:12] zero.
- R4: In level mode (kind bit 0), an armed line's raw pending bit (0x844) is set while the synchronized line equals its polarity bit (1 = high active, 0 = low active) and clears when it does not. The bit updates on the third clock edge after the line changes.
- R5: In edge mode (kind bit 1), with polarity bit 1, a rising edge of the synchronized line sets the pending bit. The bit stays set after the line returns, until it is acknowledged.
- R6: In edge mode with polarity bit 0, a falling edge sets the pending bit and a rising edge does not.
- R7: Writing a one to a bit of the acknowledge register (0x84C) clears that edge-mode pending bit on the next edge, and leaves bits written with zero unchanged. The acknowledge address reads as zero.
- R8: A level-mode bit that is acknowledged while its active level persists is pending again one cycle later.
- R9: The masked pending register (0x840) equals raw pending with bits whose hide bit is 1 removed, and `irq_o` is high exactly when that register is nonzero.
- R10: A line whose arm bit is 0 is never pending. Clearing an arm bit removes its pending bit on the next edge.
- R11: When an acknowledge and a new active edge reach the same edge-mode bit in the same cycle, the bit stays pending.
- R12: Writes to addresses that are not registers, and reads of them, change no state and return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| status_i | input | 12 | Asynchronous configuration status lines |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 12 | Byte address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that reset is held from time zero, and that a status change which matters for edge detection lasts at least one clock so that the synchronizer captures it. They also take each register write as a single-cycle strobe whose address and data are stable at the clock edge. The stimulus changes lines and write signals only on falling clock edges, holds every line change for at least one full cycle, and issues at most one write per cycle. It deliberately aligns an acknowledge with a fresh edge to reach the set-over-clear case.

// File: rtl/cfgmon_pkg.sv
`timescale 1ns/1ps
package cfgmon_pkg;

    // Number of monitored status lines; every register uses this layout.
    localparam int unsigned LINES = 12;

    // Bit positions shared by all registers.
    typedef enum int unsigned {
        ST_CHIP_OK        = 0,
        ST_LOAD_DONE      = 1,
        ST_WAKE_DONE      = 2,
        ST_CHECK_ERR      = 3,
        ST_LINK_LOAD_DONE = 4,
        ST_PART_READY     = 5,
        ST_PART_ERR       = 6,
        ST_PART_DONE      = 7,
        ST_RECONF_PIN     = 8,
        ST_CHIP_OK_PIN    = 9,
        ST_LOAD_DONE_PIN  = 10,
        ST_POWER_GOOD     = 11
    } line_pos_e;

    // Byte addresses of the register window.
    localparam int unsigned ADR_ARM      = 32'h830;
    localparam int unsigned ADR_HIDE     = 32'h834;
    localparam int unsigned ADR_KIND     = 32'h838;
    localparam int unsigned ADR_POL      = 32'h83C;
    localparam int unsigned ADR_PEND_MSK = 32'h840;
    localparam int unsigned ADR_PEND_RAW = 32'h844;
    localparam int unsigned ADR_ACK      = 32'h84C;
    localparam int unsigned ADR_LIVE     = 32'h850;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    typedef logic [LINES-1:0] line_vec_t;

    // Per-line configuration carried from the register file to the detectors.
    typedef struct packed {
        line_vec_t arm;
        line_vec_t hide;
        line_vec_t edge_mode;
        line_vec_t act_high;
    } cfg_t;

    // Pending state and its filtered view.
    typedef struct packed {
        line_vec_t raw;
        line_vec_t masked;
    } pend_t;

    // True for each line that sits at its active level.
    function automatic line_vec_t at_active(input line_vec_t level, input line_vec_t act_high);
        return ~(level ^ act_high);
    endfunction

    // Remove hidden lines from a pending vector.
    function automatic line_vec_t filter_hidden(input line_vec_t pend, input line_vec_t hide);
        return pend & ~hide;
    endfunction

endpackage

// File: rtl/cfgmon_sync.sv
`timescale 1ns/1ps
module cfgmon_sync
    import cfgmon_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  line_vec_t async_i,
    output line_vec_t cur_o,
    output line_vec_t prev_o
);

    localparam int unsigned DEPTH = STAGES + 1;

    line_vec_t chain_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[0] <= '0;
        else       chain_q[0] <= async_i;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[k] <= '0;
            else       chain_q[k] <= chain_q[k-1];
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

    // The stage behind the output always holds the output's previous value (R5).
    assert_prev_follows_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> prev_o == $past(cur_o));

endmodule

// File: rtl/cfgmon_regs.sv
`timescale 1ns/1ps
module cfgmon_regs
    import cfgmon_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  pend_t             pend_i,
    input  line_vec_t         live_i,
    output cfg_t              cfg_o,
    output line_vec_t         ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(ADR_ARM);
    localparam logic [ADDR_W-1:0] A_HIDE = ADDR_W'(ADR_HIDE);
    localparam logic [ADDR_W-1:0] A_KIND = ADDR_W'(ADR_KIND);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(ADR_POL);
    localparam logic [ADDR_W-1:0] A_PMSK = ADDR_W'(ADR_PEND_MSK);
    localparam logic [ADDR_W-1:0] A_PRAW = ADDR_W'(ADR_PEND_RAW);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ADR_ACK);
    localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(ADR_LIVE);

    cfg_t      cfg_q;
    line_vec_t wr_bits;
    logic      unused_hi;

    assign wr_bits   = wdata_i[LINES-1:0];
    assign unused_hi = ^wdata_i[DATA_W-1:LINES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                A_ARM:   cfg_q.arm       <= wr_bits;
                A_HIDE:  cfg_q.hide      <= wr_bits;
                A_KIND:  cfg_q.edge_mode <= wr_bits;
                A_POL:   cfg_q.act_high  <= wr_bits;
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;
    assign ack_o = (wr_en_i && addr_i == A_ACK) ? wr_bits : '0;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_ARM:   rdata_o[LINES-1:0] = cfg_q.arm;
            A_HIDE:  rdata_o[LINES-1:0] = cfg_q.hide;
            A_KIND:  rdata_o[LINES-1:0] = cfg_q.edge_mode;
            A_POL:   rdata_o[LINES-1:0] = cfg_q.act_high;
            A_PMSK:  rdata_o[LINES-1:0] = pend_i.masked;
            A_PRAW:  rdata_o[LINES-1:0] = pend_i.raw;
            A_LIVE:  rdata_o[LINES-1:0] = live_i;
            default: rdata_o = '0;
        endcase
    end

    // A write to the arm register is visible on the next cycle (R3).
    assert_arm_store_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i && addr_i == A_ARM |=> cfg_o.arm == $past(wr_bits));

    // A write that targets no control register leaves the configuration alone (R12).
    assert_stray_write_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i && addr_i != A_ARM && addr_i != A_HIDE && addr_i != A_KIND && addr_i != A_POL
        |=> $stable(cfg_o));

endmodule

// File: rtl/cfgmon_detect.sv
`timescale 1ns/1ps
module cfgmon_detect
    import cfgmon_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  cfg_t      cfg_i,
    input  line_vec_t cur_i,
    input  line_vec_t prev_i,
    input  line_vec_t ack_i,
    output line_vec_t pend_o
);

    line_vec_t active;

    assign active = at_active(cur_i, cfg_i.act_high);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic  hit_edge;
        logic  pend_q;
        trig_e kind;

        assign kind     = trig_e'(cfg_i.edge_mode[i]);
        assign hit_edge = active[i] && (cur_i[i] != prev_i[i]);

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pend_q <= 1'b0;
            end else if (!cfg_i.arm[i]) begin
                pend_q <= 1'b0;
            end else if (kind == TRIG_EDGE) begin
                // A new edge wins over an acknowledge in the same cycle.
                pend_q <= hit_edge | (pend_q & ~ack_i[i]);
            end else begin
                pend_q <= active[i] & ~ack_i[i];
            end
        end

        assign pend_o[i] = pend_q;

        // Level mode: an armed line at its polarity level becomes pending (R4).
        assert_level_sets_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            cfg_i.arm[i] && !cfg_i.edge_mode[i] && (cur_i[i] == cfg_i.act_high[i]) && !ack_i[i]
            |=> pend_o[i]);

        // Edge mode: pending holds until acknowledged (R5).
        assert_edge_holds_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            pend_o[i] && cfg_i.arm[i] && cfg_i.edge_mode[i] && !ack_i[i] |=> pend_o[i]);

        // Acknowledge without a fresh edge clears an edge-mode bit (R7).
        assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
            ack_i[i] && cfg_i.edge_mode[i] && (cur_i[i] == prev_i[i]) |=> !pend_o[i]);

        // A disarmed line is not pending one edge later (R10).
        assert_disarmed_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            !cfg_i.arm[i] |=> !pend_o[i]);

        // An active edge sets the bit even with an acknowledge present (R11).
        assert_edge_beats_ack_R11: assert property (@(posedge clk_i) disable iff (rst_i)
            cfg_i.arm[i] && cfg_i.edge_mode[i] && (cur_i[i] == cfg_i.act_high[i])
            && (cur_i[i] != prev_i[i]) |=> pend_o[i]);
    end

endmodule

// File: rtl/cfg_status_irq.sv
`timescale 1ns/1ps
module cfg_status_irq
    import cfgmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [LINES-1:0]  status_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    line_vec_t cur;
    line_vec_t prev;
    line_vec_t ack;
    cfg_t      cfg;
    pend_t     pend;

    cfgmon_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (status_i),
        .cur_o   (cur),
        .prev_o  (prev)
    );

    cfgmon_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend),
        .live_i  (cur),
        .cfg_o   (cfg),
        .ack_o   (ack),
        .rdata_o (rdata_o)
    );

    cfgmon_detect i_detect (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cfg_i  (cfg),
        .cur_i  (cur),
        .prev_i (prev),
        .ack_i  (ack),
        .pend_o (pend.raw)
    );

    assign pend.masked = filter_hidden(pend.raw, cfg.hide);
    assign irq_o       = |pend.masked;

    // The request is raised only for a pending line that is not hidden (R9).
    assert_irq_source_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> $countones(pend.raw & ~cfg.hide) != 0);

    // Nothing is pending in the cycle after reset is released (R1).
    assert_quiet_after_reset_R1: assert property (@(posedge clk_i)
        $fell(rst_i) |-> !irq_o);

endmodule

// File: tb/test_cfg_status_irq.sv
`timescale 1ns/1ps
module test_cfg_status_irq;

    localparam int unsigned N      = 12;
    localparam int unsigned AW     = 12;
    localparam int unsigned DW     = 32;
    localparam int unsigned WD_MAX = 20000;

    localparam logic [AW-1:0] A_ARM  = 12'h830;
    localparam logic [AW-1:0] A_HIDE = 12'h834;
    localparam logic [AW-1:0] A_KIND = 12'h838;
    localparam logic [AW-1:0] A_POL  = 12'h83C;
    localparam logic [AW-1:0] A_PMSK = 12'h840;
    localparam logic [AW-1:0] A_PRAW = 12'h844;
    localparam logic [AW-1:0] A_ACK  = 12'h84C;
    localparam logic [AW-1:0] A_LIVE = 12'h850;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  lines = '0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = A_PRAW;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    cfg_status_irq i_cfg_status_irq (
        .clk_i    (clk),
        .rst_i    (rst),
        .status_i (lines),
        .wr_en_i  (wr),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .irq_o    (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_arm, m_hide, m_kind, m_pol, m_pend;
    logic [N-1:0] hist [$];

    initial begin
        m_arm = '0; m_hide = '0; m_kind = '0; m_pol = '0; m_pend = '0;
        hist = '{12'h0, 12'h0, 12'h0};
    end

    always @(posedge clk) begin
        if (rst) begin
            m_arm = '0; m_hide = '0; m_kind = '0; m_pol = '0; m_pend = '0;
            hist = '{12'h0, 12'h0, 12'h0};
        end else begin
            logic [N-1:0] now_v, old_v, nxt;
            now_v = hist[1];
            old_v = hist[2];
            for (int i = 0; i < N; i++) begin
                bit act, edg, clr;
                act = (now_v[i] == m_pol[i]);
                edg = act && (now_v[i] != old_v[i]);
                clr = wr && (addr == A_ACK) && wdata[i];
                if (!m_arm[i])      nxt[i] = 1'b0;
                else if (m_kind[i]) nxt[i] = edg || (m_pend[i] && !clr);
                else                nxt[i] = act && !clr;
            end
            m_pend = nxt;
            if (wr) begin
                if (addr == A_ARM)  m_arm  = wdata[N-1:0];
                if (addr == A_HIDE) m_hide = wdata[N-1:0];
                if (addr == A_KIND) m_kind = wdata[N-1:0];
                if (addr == A_POL)  m_pol  = wdata[N-1:0];
            end
            hist.push_front(lines);
            void'(hist.pop_back());
        end
    end

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            A_ARM:  r[N-1:0] = m_arm;
            A_HIDE: r[N-1:0] = m_hide;
            A_KIND: r[N-1:0] = m_kind;
            A_POL:  r[N-1:0] = m_pol;
            A_PMSK: r[N-1:0] = m_pend & ~m_hide;
            A_PRAW: r[N-1:0] = m_pend;
            A_LIVE: r[N-1:0] = hist[1];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model once per clock, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && !done) begin
                chk(cur_req, "model rdata", rdata, model_read(addr));
                chk(cur_req, "model irq", {31'b0, irq}, {31'b0, |(m_pend & ~m_hide)});
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = A_PRAW; wdata = '0;
    endtask

    task automatic reg_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, "read", rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        cur_req = "R1";
        reg_rd("R1", A_ARM,  32'h0);
        reg_rd("R1", A_HIDE, 32'h0);
        reg_rd("R1", A_KIND, 32'h0);
        reg_rd("R1", A_POL,  32'h0);
        reg_rd("R1", A_PMSK, 32'h0);
        reg_rd("R1", A_PRAW, 32'h0);
        chk("R1", "irq", {31'b0, irq}, 32'h0);

        // R2: live readback, twelve bits only
        cur_req = "R2";
        @(negedge clk); lines = 12'hA5C;
        idle(3);
        reg_rd("R2", A_LIVE, 32'h0000_0A5C);
        @(negedge clk); lines = 12'hFFF;
        idle(3);
        reg_rd("R2", A_LIVE, 32'h0000_0FFF);

        // R3: control registers store twelve bits
        cur_req = "R3";
        reg_wr(A_HIDE, 32'hFFFF_F123);
        reg_rd("R3", A_HIDE, 32'h0000_0123);
        reg_wr(A_KIND, 32'hABCD_E456);
        reg_rd("R3", A_KIND, 32'h0000_0456);
        reg_wr(A_POL, 32'h0000_0789);
        reg_rd("R3", A_POL, 32'h0000_0789);
        reg_wr(A_HIDE, 32'h0);
        reg_wr(A_KIND, 32'h0);
        reg_wr(A_POL, 32'h0);

        // R12: stray address accepts no write and reads zero
        cur_req = "R12";
        reg_wr(12'h848, 32'hFFFF_FFFF);
        reg_rd("R12", 12'h848, 32'h0);
        reg_rd("R12", A_ARM, 32'h0);

        // R4: level mode, bit0 high active, bit1 low active
        cur_req = "R4";
        @(negedge clk); lines = 12'h000;
        reg_wr(A_POL, 32'h001);
        reg_wr(A_ARM, 32'h003);
        idle(4);
        reg_rd("R4", A_PRAW, 32'h002);
        @(negedge clk); lines = 12'h001;
        idle(4);
        reg_rd("R4", A_PRAW, 32'h003);
        @(negedge clk); lines = 12'h003;
        idle(4);
        reg_rd("R4", A_PRAW, 32'h001);

        // R8: acknowledge while the level persists
        cur_req = "R8";
        reg_wr(A_ACK, 32'h001);
        idle(1);
        reg_rd("R8", A_PRAW, 32'h001);

        // R9: hide filtering and request
        cur_req = "R9";
        reg_wr(A_HIDE, 32'h001);
        reg_rd("R9", A_PMSK, 32'h000);
        chk("R9", "irq hidden", {31'b0, irq}, 32'h0);
        reg_wr(A_HIDE, 32'h000);
        reg_rd("R9", A_PMSK, 32'h001);
        chk("R9", "irq shown", {31'b0, irq}, 32'h1);

        // R10: disarming clears pending
        cur_req = "R10";
        reg_wr(A_ARM, 32'h000);
        reg_rd("R10", A_PRAW, 32'h000);
        chk("R10", "irq", {31'b0, irq}, 32'h0);

        // R5/R6: edge mode, bits 4,5 rising, bits 6,7 falling
        cur_req = "R5";
        @(negedge clk); lines = 12'h0C0;
        idle(4);
        reg_wr(A_KIND, 32'h0F0);
        reg_wr(A_POL,  32'h030);
        reg_wr(A_ARM,  32'h0F0);
        idle(3);
        reg_rd("R5", A_PRAW, 32'h000);
        @(negedge clk); lines = 12'h0D0;
        @(negedge clk); lines = 12'h0C0;
        idle(4);
        reg_rd("R5", A_PRAW, 32'h010);
        cur_req = "R6";
        @(negedge clk); lines = 12'h080;
        idle(4);
        reg_rd("R6", A_PRAW, 32'h050);
        @(negedge clk); lines = 12'h0C0;
        idle(4);
        reg_rd("R6", A_PRAW, 32'h050);

        // R7: acknowledge selected bits
        cur_req = "R7";
        reg_wr(A_ACK, 32'h010);
        reg_rd("R7", A_PRAW, 32'h040);
        reg_rd("R7", A_ACK, 32'h000);

        // R11: new edge meets acknowledge in the same cycle
        cur_req = "R11";
        @(negedge clk); lines = 12'h0E0;
        idle(4);
        reg_rd("R11", A_PRAW, 32'h060);
        @(negedge clk); lines = 12'h0C0;
        idle(3);
        @(negedge clk); lines = 12'h0E0;
        idle(1);
        reg_wr(A_ACK, 32'h020);
        reg_rd("R11", A_PRAW, 32'h060);
        idle(3);
        reg_rd("R11", A_PRAW, 32'h060);

        idle(2);
        finish_run();
    end

endmodule